// File: doc/BRIEF.md
# Ancillary Packet Formatter

This block sits beside a video stream multiplexer and handles user ancillary packets in both directions. In insert mode it offers a packet slot with a one-cycle ready strobe. The user answers with an enable pulse two cycles later. Two cycles after that, the user streams 8-bit payload words: the data identifier, the secondary identifier, the data count, and then as many user data words as the count says. The block emits a 10-bit ancillary word stream. That stream starts with the three-word flag, carries every payload word widened with a parity bit and its inverse, and ends with a checksum word that the block computes itself.

In extract mode the block watches a 10-bit word stream for the ancillary flag. It strips each following word back to 8 bits and presents the data identifier through the last user data word. An early enable output rises two cycles before the first word appears. The received checksum is compared against a locally computed one and is not passed on.

Scheduling of packets into blanking, the stream multiplexer itself and any scrambling are handled elsewhere.

Top module: `anc_fmt`

## Requirements
- R1: While reset is held, `rdyOut`, `ancOutValid`, `pktOutValid`, `extEn` and `errPulse` are all low.
- R2: In insert mode `rdyOut` is high for exactly one cycle per offer. `userEn` must be high during the cycle that begins two rising edges after the edge that raised `rdyOut`. If it is not, `errPulse` is high for the next cycle, no word is emitted, and a new offer follows one cycle later.
- R3: When the enable is accepted, `ancOutValid` rises in the next cycle with `ancOut` = 000h, followed by 3FFh and 3FFh on the two following cycles.
- R4: The first payload word (data identifier) is sampled from `pktIn` two cycles after the cycle in which `userEn` was high. Each later word is sampled one cycle after the one before it. The widened data identifier appears on `ancOut` directly after the second 3FFh.
- R5: Each payload byte b is emitted as {~p, p, b}, where p = XOR of b[7:0] (even parity over bits 8..0). Bit 9 is the inverse of bit 8.
- R6: The third payload word is the data count DC (0..255). Exactly DC user words follow it, the checksum follows the last one, and `ancOutValid` falls in the next cycle.
- R7: The checksum word is {~s[8], s}, where s is the 9-bit sum modulo 512 of bits 8..0 of all emitted words from the data identifier through the last user word.
- R8: In extract mode, a valid 000h, 3FFh, 3FFh sequence on `ancIn` starts a packet. `pktOut` then shows bits 7..0 of the data identifier through the last user word, one per cycle and in order, with `pktOutValid` high. The checksum word is never shown.
- R9: `extEn` rises two cycles before the first `pktOutValid` cycle. It stays high through the last presented word and is low in the cycle after.
- R10: If the received checksum word differs from the locally computed {~s[8], s}, `errPulse` is high for one cycle. That cycle is the one in which the last user word is presented.
- R11: In extract mode `rdyOut` and `ancOutValid` stay low.
- R12: If `ancInValid` drops while a packet is being received, the packet is abandoned. In the next cycle `errPulse` is high and both `extEn` and `pktOutValid` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeExtract | input | 1 | 0 = insert mode, 1 = extract mode |
| rdyOut | output | 1 | One-cycle offer of a packet slot (insert mode) |
| userEn | input | 1 | User acceptance of the offer (insert mode) |
| pktIn | input | 8 | Payload words from the user (insert mode) |
| ancOut | output | 10 | Formatted ancillary words (insert mode) |
| ancOutValid | output | 1 | `ancOut` carries a word |
| ancIn | input | 10 | Incoming ancillary words (extract mode) |
| ancInValid | input | 1 | `ancIn` carries a word |
| pktOut | output | 8 | Stripped payload words (extract mode) |
| pktOutValid | output | 1 | `pktOut` carries a word |
| extEn | output | 1 | Early enable framing the extracted words |
| errPulse | output | 1 | One-cycle error: missed enable, checksum mismatch or broken packet |

## Verification
A wrong word index or a stale data count shows up at the ports as a checksum placed at the wrong position, or as `ancOutValid` falling early or late. Both are visible within one packet length. A wrong parity or sum bit corrupts a single output word, so sweeps cover every byte value in both directions. A wrong state in the handshake or the flag hunt shows within three cycles, either as a missing flag word or as `extEn` and `pktOutValid` out of their fixed two-cycle relation.

// File: rtl/anc_fmt_pkg.sv
package anc_fmt_pkg;
  localparam int PAY_W  = 8;
  localparam int WORD_W = PAY_W + 2;
  localparam int SUM_W  = PAY_W + 1;
  localparam int IDX_W  = PAY_W + 1;
  localparam int HDR_LAST = 2;

  typedef enum logic [3:0] {
    S_IDLE, S_OFFER, S_GAP, S_ENCHK, S_FLAG1, S_FLAG2, S_BODY, S_CSUM,
    S_XH0, S_XH1, S_XH2, S_XDATA, S_XCSUM, S_XTAIL
  } fmtState_e;

  typedef enum logic [2:0] {
    OS_NONE, OS_ZERO, OS_ONES, OS_WORD, OS_CSUM
  } outSel_e;

  typedef struct packed {
    outSel_e outSel;
    logic    sumClr;
    logic    sumAddIns;
    logic    sumAddExt;
    logic    xPend;
    logic    xAbort;
  } fmtStrobe_t;

  function automatic logic [WORD_W-1:0] widenWord(input logic [PAY_W-1:0] b);
    logic p;
    p = ^b;
    return {~p, p, b};
  endfunction
endpackage

// File: rtl/anc_fmt_ctrl.sv
module anc_fmt_ctrl
  import anc_fmt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeExtract,
  input  logic              userEn,
  input  logic [PAY_W-1:0]  stageIns,
  input  logic [WORD_W-1:0] ancIn,
  input  logic              ancInValid,
  input  logic              sumMatch,
  output fmtStrobe_t        st,
  output logic              rdyOut,
  output logic              extEn,
  output logic              errPulse
);
  fmtState_e         state, stateN;
  logic [IDX_W-1:0]  idx, idxN;
  logic [PAY_W-1:0]  dcReg, dcN;
  logic              enN, errN;
  logic [PAY_W-1:0]  dcEff;
  logic [IDX_W-1:0]  lastIdx;
  logic              isZero, isOnes;

  assign isZero = ancInValid && (ancIn == '0);
  assign isOnes = ancInValid && (ancIn == '1);
  assign rdyOut = (state == S_OFFER);

  // length bookkeeping shared by both directions
  always_comb begin
    if (idx == IDX_W'(HDR_LAST))
      dcEff = modeExtract ? ancIn[PAY_W-1:0] : stageIns;
    else
      dcEff = dcReg;
    lastIdx = IDX_W'(HDR_LAST) + IDX_W'(dcEff);
  end

  always_comb begin
    stateN = state;
    idxN   = idx;
    dcN    = dcReg;
    enN    = extEn;
    errN   = 1'b0;
    st     = '0;
    st.outSel = OS_NONE;
    unique case (state)
      S_IDLE:  stateN = modeExtract ? S_XH0 : S_OFFER;
      S_OFFER: stateN = modeExtract ? S_XH0 : S_GAP;
      S_GAP:   stateN = modeExtract ? S_XH0 : S_ENCHK;
      S_ENCHK: begin
        if (modeExtract) stateN = S_XH0;
        else if (userEn) begin
          st.outSel = OS_ZERO;
          stateN    = S_FLAG1;
        end else begin
          errN   = 1'b1;
          stateN = S_IDLE;
        end
      end
      S_FLAG1: begin
        st.outSel = OS_ONES;
        stateN    = S_FLAG2;
      end
      S_FLAG2: begin
        st.outSel = OS_ONES;
        st.sumClr = 1'b1;
        idxN      = '0;
        stateN    = S_BODY;
      end
      S_BODY: begin
        st.outSel    = OS_WORD;
        st.sumAddIns = 1'b1;
        if (idx == IDX_W'(HDR_LAST)) dcN = stageIns;
        if (idx >= IDX_W'(HDR_LAST) && idx == lastIdx) stateN = S_CSUM;
        else idxN = idx + 1'b1;
      end
      S_CSUM: begin
        st.outSel = OS_CSUM;
        stateN    = S_IDLE;
      end
      S_XH0: begin
        if (!modeExtract) stateN = S_IDLE;
        else if (isZero) stateN = S_XH1;
      end
      S_XH1, S_XH2: begin
        if (!modeExtract) stateN = S_IDLE;
        else if (ancInValid) begin
          if (isOnes) begin
            if (state == S_XH1) stateN = S_XH2;
            else begin
              stateN    = S_XDATA;
              idxN      = '0;
              st.sumClr = 1'b1;
              enN       = 1'b1;
            end
          end else if (isZero) stateN = S_XH1;
          else stateN = S_XH0;
        end
      end
      S_XDATA: begin
        if (!ancInValid) begin
          st.xAbort = 1'b1;
          errN      = 1'b1;
          enN       = 1'b0;
          stateN    = S_XH0;
        end else begin
          st.xPend     = 1'b1;
          st.sumAddExt = 1'b1;
          if (idx == IDX_W'(HDR_LAST)) dcN = ancIn[PAY_W-1:0];
          if (idx >= IDX_W'(HDR_LAST) && idx == lastIdx) stateN = S_XCSUM;
          else idxN = idx + 1'b1;
        end
      end
      S_XCSUM: begin
        if (!ancInValid) begin
          st.xAbort = 1'b1;
          errN      = 1'b1;
          enN       = 1'b0;
          stateN    = S_XH0;
        end else begin
          errN   = !sumMatch;
          stateN = S_XTAIL;
        end
      end
      S_XTAIL: begin
        enN    = 1'b0;
        stateN = S_XH0;
      end
      default: stateN = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      idx      <= '0;
      dcReg    <= '0;
      extEn    <= 1'b0;
      errPulse <= 1'b0;
    end else begin
      state    <= stateN;
      idx      <= idxN;
      dcReg    <= dcN;
      extEn    <= enN;
      errPulse <= errN;
    end
  end
endmodule

// File: rtl/anc_fmt_dp.sv
module anc_fmt_dp
  import anc_fmt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  fmtStrobe_t        st,
  input  logic [PAY_W-1:0]  pktIn,
  input  logic [WORD_W-1:0] ancIn,
  output logic [PAY_W-1:0]  stageIns,
  output logic [WORD_W-1:0] ancOut,
  output logic              ancOutValid,
  output logic [PAY_W-1:0]  pktOut,
  output logic              pktOutValid,
  output logic              sumMatch
);
  logic [WORD_W-1:0] stageExt;
  logic [SUM_W-1:0]  sum;
  logic              pendReg;
  logic [WORD_W-1:0] wideWord, csWord, outN;

  assign wideWord = widenWord(stageIns);
  assign csWord   = {~sum[SUM_W-1], sum};
  assign sumMatch = (ancIn == csWord);

  always_comb begin
    unique case (st.outSel)
      OS_ZERO: outN = '0;
      OS_ONES: outN = '1;
      OS_WORD: outN = wideWord;
      OS_CSUM: outN = csWord;
      default: outN = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stageIns    <= '0;
      stageExt    <= '0;
      sum         <= '0;
      pendReg     <= 1'b0;
      ancOut      <= '0;
      ancOutValid <= 1'b0;
      pktOut      <= '0;
      pktOutValid <= 1'b0;
    end else begin
      stageIns    <= pktIn;
      stageExt    <= ancIn;
      ancOut      <= outN;
      ancOutValid <= (st.outSel != OS_NONE);
      if (st.sumClr)         sum <= '0;
      else if (st.sumAddIns) sum <= sum + wideWord[SUM_W-1:0];
      else if (st.sumAddExt) sum <= sum + ancIn[SUM_W-1:0];
      pendReg     <= st.xPend;
      pktOut      <= stageExt[PAY_W-1:0];
      pktOutValid <= pendReg && !st.xAbort;
    end
  end
endmodule

// File: rtl/anc_fmt.sv
module anc_fmt
  import anc_fmt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeExtract,
  output logic              rdyOut,
  input  logic              userEn,
  input  logic [PAY_W-1:0]  pktIn,
  output logic [WORD_W-1:0] ancOut,
  output logic              ancOutValid,
  input  logic [WORD_W-1:0] ancIn,
  input  logic              ancInValid,
  output logic [PAY_W-1:0]  pktOut,
  output logic              pktOutValid,
  output logic              extEn,
  output logic              errPulse
);
  fmtStrobe_t       st;
  logic [PAY_W-1:0] stageIns;
  logic             sumMatch;

  anc_fmt_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .modeExtract(modeExtract), .userEn(userEn),
    .stageIns(stageIns), .ancIn(ancIn), .ancInValid(ancInValid),
    .sumMatch(sumMatch), .st(st), .rdyOut(rdyOut), .extEn(extEn),
    .errPulse(errPulse)
  );

  anc_fmt_dp u_dp (
    .clk(clk), .rstN(rstN), .st(st), .pktIn(pktIn), .ancIn(ancIn),
    .stageIns(stageIns), .ancOut(ancOut), .ancOutValid(ancOutValid),
    .pktOut(pktOut), .pktOutValid(pktOutValid), .sumMatch(sumMatch)
  );
endmodule

// File: rtl/anc_fmt_chk.sv
module anc_fmt_chk
  import anc_fmt_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              modeExtract,
  input logic              rdyOut,
  input logic              userEn,
  input logic [WORD_W-1:0] ancOut,
  input logic              ancOutValid,
  input logic              pktOutValid,
  input logic              extEn,
  input logic              errPulse
);
  // R2
  rdy_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdyOut |=> !rdyOut);

  // R2
  err_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    errPulse |=> !errPulse);

  // R3
  flag_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ancOutValid) |-> (ancOut == '0 && $past(userEn)));

  // R5
  word_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    ancOutValid |-> (ancOut == '0 || ancOut == '1 ||
                     ancOut[WORD_W-1] != ancOut[WORD_W-2]));

  // R9
  en_frame_chk: assert property (@(posedge clk) disable iff (!rstN)
    pktOutValid |-> extEn);

  // R9
  en_lead_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pktOutValid) |-> $past(extEn, 2));

  // R11
  rdy_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdyOut |-> !$past(modeExtract));
endmodule

bind anc_fmt anc_fmt_chk u_chk (
  .clk(clk), .rstN(rstN), .modeExtract(modeExtract), .rdyOut(rdyOut),
  .userEn(userEn), .ancOut(ancOut), .ancOutValid(ancOutValid),
  .pktOutValid(pktOutValid), .extEn(extEn), .errPulse(errPulse)
);

// File: tb/anc_fmt_test.sv
module anc_fmt_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       modeExtract = 1'b0;
  logic       rdyOut;
  logic       userEn = 1'b0;
  logic [7:0] pktIn = '0;
  logic [9:0] ancOut;
  logic       ancOutValid;
  logic [9:0] ancIn = '0;
  logic       ancInValid = 1'b0;
  logic [7:0] pktOut;
  logic       pktOutValid;
  logic       extEn;
  logic       errPulse;

  int checks = 0;
  int fails = 0;
  logic [7:0] w [0:259];
  int n;

  always #4 clk = ~clk;

  anc_fmt uut (
    .clk(clk), .rstN(rstN), .modeExtract(modeExtract), .rdyOut(rdyOut),
    .userEn(userEn), .pktIn(pktIn), .ancOut(ancOut), .ancOutValid(ancOutValid),
    .ancIn(ancIn), .ancInValid(ancInValid), .pktOut(pktOut),
    .pktOutValid(pktOutValid), .extEn(extEn), .errPulse(errPulse)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [9:0] wid(input logic [7:0] b);
    int ones = 0;
    for (int i = 0; i < 8; i++) ones += b[i];
    return {10'((1 - ones % 2) * 512 + (ones % 2) * 256)} | {2'b00, b};
  endfunction

  function automatic logic [9:0] csum();
    int s = 0;
    for (int i = 0; i < n; i++) s = (s + (wid(w[i]) % 512)) % 512;
    return 10'(((s / 256) == 0 ? 512 : 0) + s);
  endfunction

  task automatic build(input int did, input int sdid, input int dc, input int seed);
    w[0] = 8'(did); w[1] = 8'(sdid); w[2] = 8'(dc);
    for (int i = 0; i < dc; i++) w[3 + i] = 8'((seed * i * 37 + seed * 11 + i) % 256);
    n = 3 + dc;
  endtask

  task automatic waitRdy();
    int guard = 0;
    @(negedge clk);
    while (!rdyOut && guard < 40) begin
      @(negedge clk);
      guard++;
    end
    chk(rdyOut, "R2 offer", rdyOut, 1);
  endtask

  task automatic runInsert();
    logic [9:0] e;
    waitRdy();
    @(negedge clk);
    chk(!rdyOut, "R2 offer width", rdyOut, 0);
    @(negedge clk);
    userEn = 1'b1;
    for (int j = 0; j <= n + 4; j++) begin
      @(negedge clk);
      if (j == 0) userEn = 1'b0;
      if (j <= n + 3) begin
        if (j == 0) e = 10'h000;
        else if (j < 3) e = 10'h3FF;
        else if (j < n + 3) e = wid(w[j - 3]);
        else e = csum();
        if (j < 3)
          chk(ancOutValid && ancOut == e, "R3 flag", ancOut, e);
        else if (j == 3)
          chk(ancOutValid && ancOut == e, "R4 first word", ancOut, e);
        else if (j < n + 3)
          chk(ancOutValid && ancOut == e, "R5 word", ancOut, e);
        else
          chk(ancOutValid && ancOut == e, "R7 checksum", ancOut, e);
      end else begin
        chk(!ancOutValid, "R6 end of packet", ancOutValid, 0);
      end
      if (j >= 1 && j <= n) pktIn = w[j - 1];
      else pktIn = 8'hA5;
    end
  endtask

  task automatic runMissedEn();
    waitRdy();
    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    chk(errPulse && !ancOutValid, "R2 missed enable", {errPulse, ancOutValid}, 2);
    @(negedge clk);
    chk(rdyOut && !errPulse, "R2 re-offer", {rdyOut, errPulse}, 2);
  endtask

  function automatic logic [9:0] sWord(input int j, input bit bad);
    if (j == 0) return 10'h000;
    if (j < 3) return 10'h3FF;
    if (j < n + 3) return wid(w[j - 3]);
    return bad ? (csum() ^ 10'h001) : csum();
  endfunction

  task automatic toMode(input bit m);
    @(negedge clk);
    modeExtract = m;
    ancInValid = 1'b0;
    for (int k = 0; k < 4; k++) @(negedge clk);
  endtask

  task automatic runExtract(input bit bad);
    for (int j = 0; j <= n + 6; j++) begin
      @(negedge clk);
      chk(!rdyOut && !ancOutValid, "R11 insert quiet", {rdyOut, ancOutValid}, 0);
      chk(extEn == (j >= 3 && j <= n + 4), "R9 early enable", extEn, (j >= 3 && j <= n + 4));
      if (j >= 5 && j <= n + 4)
        chk(pktOutValid && pktOut == w[j - 5], "R8 stripped word", pktOut, w[j - 5]);
      else
        chk(!pktOutValid, "R8 no word", pktOutValid, 0);
      if (j == n + 4)
        chk(errPulse == bad, "R10 checksum compare", errPulse, bad);
      if (j < n + 4) begin
        ancIn = sWord(j, bad);
        ancInValid = 1'b1;
      end else begin
        ancIn = 10'h155;
        ancInValid = 1'b0;
      end
    end
  endtask

  task automatic runAbort();
    for (int j = 0; j <= 7; j++) begin
      @(negedge clk);
      if (j == 5)
        chk(pktOutValid && pktOut == w[0] && extEn, "R12 before break", pktOut, w[0]);
      if (j == 6)
        chk(errPulse && !extEn && !pktOutValid, "R12 abandon",
            {errPulse, extEn, pktOutValid}, 4);
      if (j < 5) begin
        ancIn = sWord(j, 1'b0);
        ancInValid = 1'b1;
      end else begin
        ancInValid = 1'b0;
      end
    end
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      // R1
      chk(!rdyOut && !ancOutValid && !pktOutValid && !extEn && !errPulse, "R1 reset",
          {rdyOut, ancOutValid, pktOutValid, extEn, errPulse}, 0);
    end
    rstN = 1'b1;

    // R6 lengths, R5 byte sweep
    build(8'h41, 8'h05, 0, 1);   runInsert();
    build(8'h60, 8'h60, 1, 3);   runInsert();
    build(8'h7F, 8'h80, 5, 7);   runInsert();
    runMissedEn();
    build(8'hFF, 8'h01, 255, 0);
    for (int i = 0; i < 255; i++) w[3 + i] = 8'(i);
    runInsert();
    build(8'h12, 8'hC3, 17, 9);  runInsert();

    toMode(1'b1);
    build(8'h45, 8'h01, 3, 5);   runExtract(1'b0);
    build(8'hFF, 8'h01, 255, 0);
    for (int i = 0; i < 255; i++) w[3 + i] = 8'(i);
    runExtract(1'b0);
    build(8'h50, 8'h22, 0, 2);   runExtract(1'b0);
    build(8'h51, 8'h33, 6, 4);   runExtract(1'b1);
    build(8'h52, 8'h44, 9, 6);   runAbort();
    build(8'h53, 8'h55, 2, 8);   runExtract(1'b0);

    toMode(1'b0);
    build(8'h61, 8'h0A, 4, 12);  runInsert();

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule